// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer for a system-on-chip. It has a small 32-bit register bus and a down-counter. The counter runs on a 32.768 kHz slow clock, so 32768 steps make one second and the useful timeout range is 3 to 60 seconds. Software writes a reload value and a pre-timeout threshold, each as two 16-bit halves. Writing the low half of the reload commits both values. They are then carried into the slow domain by a toggle handshake, and a busy flag stays visible until the counter holds them.

When the counter steps down onto the threshold, a sticky interrupt flag is set. When it steps down to zero, a sticky reset flag is set. That flag becomes a reset request if reset is enabled. A key-protected lock guards every register, so a runaway program cannot disarm the watchdog by accident. Software reads the count as a high half and then a low half, and the two halves always belong to the same sample.

Top module: `wdg_top`

## Requirements
- R1: After reset all registers read 0, the block is locked, the count reads 0, and `irq_o` and `rst_req_o` are low.
- R2: Writing 0x0000E551 to the lock register (offset 0x20) unlocks the block, and any other value locks it. Offset 0x20 reads 1 in bit 0 while unlocked. While locked, writes to every other offset are discarded.
- R3: The control register (offset 0x08) holds four bits and reads them back. Bit 0 enables the interrupt, bit 1 enables counting, bit 2 is a stored mode flag with no function, and bit 3 enables the reset request.
- R4: The reload value is written as bits 31:16 at offset 0x04 and bits 15:0 at offset 0x00. The pre-timeout value is written as bits 31:16 at offset 0x30 and bits 15:0 at offset 0x2C. A write to offset 0x00 commits both values, and the counter then holds exactly the new reload value.
- R5: Bit 4 of the raw status register (offset 0x10) reads 1 from the commit until the counter domain has taken the values. This lasts two to three slow-clock periods plus two bus cycles. A write to offset 0x00 while that bit is 1 is discarded.
- R6: While control bit 1 is set, the counter decrements once per slow clock. While bit 1 is clear, the count holds. Once the count reaches 0 it stays at 0 until the next reload.
- R7: A read of offset 0x1C returns count bits 31:16 and captures bits 15:0 of the same sample. A following read of offset 0x18 returns those captured bits.
- R8: When the count steps onto the pre-timeout value, raw status bit 0 is set. It stays set until a 1 is written to bit 0 of the clear register (offset 0x0C).
- R9: `irq_o` is high exactly when raw bit 0 is set, control bit 0 is set, and bit 0 of the mask register (offset 0x14) is clear.
- R10: When the count steps from 1 to 0, raw status bit 3 is set. It stays set until a 1 is written to bit 3 of the clear register. `rst_req_o` is high exactly when raw bit 3 and control bit 3 are both set.
- R11: Writes to the clear register obey the lock. While locked, a clear write leaves the raw status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | 32.768 kHz counting clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released per domain |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 6 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, selected by offset |
| irq_o | output | 1 | Pre-timeout interrupt |
| rst_req_o | output | 1 | System reset request |

## Verification
The assertions check on every cycle that:
- control holds while locked;
- a reload refused for busy leaves the committed value untouched;
- the count holds when counting is off and stays at zero once it gets there;
- the interrupt flag and the reset request persist until a bus write.

Only the bench scenarios can show the timing, because it crosses clock domains:
- the busy window length;
- the number of slow cycles from enable to the early warning and to expiry under random reload and threshold pairs;
- that the two count halves read back coherently.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_LOAD_LO = 6'h00;
  localparam logic [ADDR_W-1:0] A_LOAD_HI = 6'h04;
  localparam logic [ADDR_W-1:0] A_CTRL    = 6'h08;
  localparam logic [ADDR_W-1:0] A_CLR     = 6'h0C;
  localparam logic [ADDR_W-1:0] A_RAW     = 6'h10;
  localparam logic [ADDR_W-1:0] A_MASK    = 6'h14;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 6'h18;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_LOCK    = 6'h20;
  localparam logic [ADDR_W-1:0] A_PRE_LO  = 6'h2C;
  localparam logic [ADDR_W-1:0] A_PRE_HI  = 6'h30;

  localparam logic [15:0] UNLOCK_KEY = 16'hE551;

  localparam int RAW_INT  = 0;
  localparam int RAW_RST  = 3;
  localparam int RAW_BUSY = 4;

  typedef struct packed {
    logic rst_en;
    logic mode;
    logic cnt_en;
    logic int_en;
  } ctrl_t;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_req_s_i,
  input  logic          cnt_en_s_i,
  input  logic          snap_ack_s_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic [DW-1:0] pre_val_i,
  output logic          ld_ack_o,
  output logic          pre_tgl_o,
  output logic          exp_tgl_o,
  output logic          snap_tgl_o,
  output logic [DW-1:0] snap_data_o,
  output logic [DW-1:0] cnt_o,
  output logic          load_evt_o
);
  logic [DW-1:0] cnt_q, cnt_d, snap_q, snap_d, cnt_m1;
  logic          seen_q, seen_d, pre_q, pre_d, exp_q, exp_d, stg_q, stg_d;
  logic          load_evt, dec;

  always_comb begin
    load_evt = (ld_req_s_i != seen_q);
    dec      = cnt_en_s_i && (cnt_q != '0) && !load_evt;
    cnt_m1   = cnt_q - 1'b1;
    cnt_d    = cnt_q;
    seen_d   = seen_q;
    pre_d    = pre_q;
    exp_d    = exp_q;
    snap_d   = snap_q;
    stg_d    = stg_q;
    if (load_evt) begin
      cnt_d  = ld_val_i;
      seen_d = ld_req_s_i;
    end else if (dec) begin
      cnt_d = cnt_m1;
      if (cnt_m1 == pre_val_i) pre_d = ~pre_q;
      if (cnt_m1 == '0)        exp_d = ~exp_q;
    end
    // publish a fresh sample once the bus side has taken the last one
    if (snap_ack_s_i == stg_q) begin
      snap_d = cnt_q;
      stg_d  = ~stg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
      seen_q <= 1'b0;
      pre_q  <= 1'b0;
      exp_q  <= 1'b0;
      stg_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      snap_q <= snap_d;
      seen_q <= seen_d;
      pre_q  <= pre_d;
      exp_q  <= exp_d;
      stg_q  <= stg_d;
    end
  end

  assign ld_ack_o    = seen_q;
  assign pre_tgl_o   = pre_q;
  assign exp_tgl_o   = exp_q;
  assign snap_tgl_o  = stg_q;
  assign snap_data_o = snap_q;
  assign cnt_o       = cnt_q;
  assign load_evt_o  = load_evt;
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              ld_ack_s_i,
  input  logic              pre_tgl_s_i,
  input  logic              exp_tgl_s_i,
  input  logic              snap_tgl_s_i,
  input  logic [DW-1:0]     snap_data_i,
  output logic              ld_req_o,
  output logic              snap_ack_o,
  output ctrl_t             ctrl_o,
  output logic [DW-1:0]     ld_val_o,
  output logic [DW-1:0]     pre_val_o,
  output logic              unlocked_o,
  output logic              busy_o,
  output logic              int_raw_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int HW = DW / 2;

  logic          unl_q, unl_d, mask_q, mask_d;
  ctrl_t         ctrl_q, ctrl_d;
  logic [HW-1:0] lhi_q, lhi_d, llo_q, llo_d, phi_q, phi_d, plo_q, plo_d;
  logic [HW-1:0] hold_q, hold_d;
  logic [DW-1:0] ldv_q, ldv_d, prv_q, prv_d, cap_q, cap_d;
  logic          req_q, req_d, iraw_q, iraw_d, rraw_q, rraw_d;
  logic          pseen_q, pseen_d, eseen_q, eseen_d, sseen_q, sseen_d;
  logic          wr_any, wr_ok, busy;

  assign wr_any = bus_sel_i && bus_wr_i;
  assign wr_ok  = wr_any && unl_q;
  assign busy   = (req_q != ld_ack_s_i);

  always_comb begin
    unl_d   = unl_q;   mask_d  = mask_q;  ctrl_d  = ctrl_q;
    lhi_d   = lhi_q;   llo_d   = llo_q;   phi_d   = phi_q;   plo_d = plo_q;
    ldv_d   = ldv_q;   prv_d   = prv_q;   req_d   = req_q;
    iraw_d  = iraw_q;  rraw_d  = rraw_q;  cap_d   = cap_q;   hold_d = hold_q;
    pseen_d = pseen_q; eseen_d = eseen_q; sseen_d = sseen_q;

    if (wr_any && bus_addr_i == A_LOCK)
      unl_d = (bus_wdata_i == {{(DW-16){1'b0}}, UNLOCK_KEY});

    if (wr_ok) begin
      case (bus_addr_i)
        A_CTRL:    ctrl_d = ctrl_t'(bus_wdata_i[3:0]);
        A_MASK:    mask_d = bus_wdata_i[0];
        A_LOAD_HI: lhi_d  = bus_wdata_i[HW-1:0];
        A_PRE_HI:  phi_d  = bus_wdata_i[HW-1:0];
        A_PRE_LO:  plo_d  = bus_wdata_i[HW-1:0];
        A_LOAD_LO: begin
          if (!busy) begin
            llo_d = bus_wdata_i[HW-1:0];
            ldv_d = {lhi_q, bus_wdata_i[HW-1:0]};
            prv_d = {phi_q, plo_q};
            req_d = ~req_q;
          end
        end
        A_CLR: begin
          if (bus_wdata_i[RAW_INT]) iraw_d = 1'b0;
          if (bus_wdata_i[RAW_RST]) rraw_d = 1'b0;
        end
        default: ;
      endcase
    end

    // events from the counting domain win over a clear in the same cycle
    if (pre_tgl_s_i != pseen_q) begin
      pseen_d = pre_tgl_s_i;
      iraw_d  = 1'b1;
    end
    if (exp_tgl_s_i != eseen_q) begin
      eseen_d = exp_tgl_s_i;
      rraw_d  = 1'b1;
    end
    if (snap_tgl_s_i != sseen_q) begin
      sseen_d = snap_tgl_s_i;
      cap_d   = snap_data_i;
    end
    if (bus_sel_i && bus_rd_i && bus_addr_i == A_CNT_HI)
      hold_d = cap_q[HW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unl_q   <= 1'b0;   mask_q  <= 1'b0;   ctrl_q  <= '0;
      lhi_q   <= '0;     llo_q   <= '0;     phi_q   <= '0;    plo_q <= '0;
      ldv_q   <= '0;     prv_q   <= '0;     req_q   <= 1'b0;
      iraw_q  <= 1'b0;   rraw_q  <= 1'b0;   cap_q   <= '0;    hold_q <= '0;
      pseen_q <= 1'b0;   eseen_q <= 1'b0;   sseen_q <= 1'b0;
    end else begin
      unl_q   <= unl_d;   mask_q  <= mask_d;  ctrl_q  <= ctrl_d;
      lhi_q   <= lhi_d;   llo_q   <= llo_d;   phi_q   <= phi_d;   plo_q <= plo_d;
      ldv_q   <= ldv_d;   prv_q   <= prv_d;   req_q   <= req_d;
      iraw_q  <= iraw_d;  rraw_q  <= rraw_d;  cap_q   <= cap_d;   hold_q <= hold_d;
      pseen_q <= pseen_d; eseen_q <= eseen_d; sseen_q <= sseen_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_LOAD_LO: bus_rdata_o[HW-1:0] = llo_q;
      A_LOAD_HI: bus_rdata_o[HW-1:0] = lhi_q;
      A_PRE_LO:  bus_rdata_o[HW-1:0] = plo_q;
      A_PRE_HI:  bus_rdata_o[HW-1:0] = phi_q;
      A_CTRL:    bus_rdata_o[3:0]    = ctrl_q;
      A_MASK:    bus_rdata_o[0]      = mask_q;
      A_LOCK:    bus_rdata_o[0]      = unl_q;
      A_CNT_HI:  bus_rdata_o[HW-1:0] = cap_q[DW-1:HW];
      A_CNT_LO:  bus_rdata_o[HW-1:0] = hold_q;
      A_RAW: begin
        bus_rdata_o[RAW_INT]  = iraw_q;
        bus_rdata_o[RAW_RST]  = rraw_q;
        bus_rdata_o[RAW_BUSY] = busy;
      end
      default: ;
    endcase
  end

  assign ld_req_o   = req_q;
  assign snap_ack_o = sseen_q;
  assign ctrl_o     = ctrl_q;
  assign ld_val_o   = ldv_q;
  assign pre_val_o  = prv_q;
  assign unlocked_o = unl_q;
  assign busy_o     = busy;
  assign int_raw_o  = iraw_q;
  assign irq_o      = iraw_q && ctrl_q.int_en && !mask_q;
  assign rst_req_o  = rraw_q && ctrl_q.rst_en;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int N_TO_SLOW = 3;
  localparam int N_TO_BUS  = 4;

  logic                 bus_rst_n, slow_rst_n;
  logic                 ld_req, snap_ack, ld_ack, pre_tgl, exp_tgl, snap_tgl;
  logic                 unlocked, busy, int_raw, load_evt;
  ctrl_t                ctrl;
  logic [DW-1:0]        ld_val, pre_val, snap_data, cnt;
  logic [N_TO_SLOW-1:0] to_slow, at_slow;
  logic [N_TO_BUS-1:0]  to_bus, at_bus;
  logic                 cnt_en_s;

  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_bus_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(bus_rst_n));
  wdg_rst_sync #(.STAGES(SYNC_STAGES)) u_slow_rst (
    .clk_i(slow_clk_i), .rst_ni(rst_ni), .rst_no(slow_rst_n));

  assign to_slow = {snap_ack, ctrl.cnt_en, ld_req};
  wdg_sync #(.W(N_TO_SLOW), .STAGES(SYNC_STAGES)) u_sync_slow (
    .clk_i(slow_clk_i), .rst_ni(slow_rst_n), .d_i(to_slow), .q_o(at_slow));
  assign cnt_en_s = at_slow[1];

  assign to_bus = {snap_tgl, exp_tgl, pre_tgl, ld_ack};
  wdg_sync #(.W(N_TO_BUS), .STAGES(SYNC_STAGES)) u_sync_bus (
    .clk_i(clk_i), .rst_ni(bus_rst_n), .d_i(to_bus), .q_o(at_bus));

  wdg_regs #(.DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(bus_rst_n),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .ld_ack_s_i(at_bus[0]), .pre_tgl_s_i(at_bus[1]), .exp_tgl_s_i(at_bus[2]),
    .snap_tgl_s_i(at_bus[3]), .snap_data_i(snap_data),
    .ld_req_o(ld_req), .snap_ack_o(snap_ack), .ctrl_o(ctrl),
    .ld_val_o(ld_val), .pre_val_o(pre_val), .unlocked_o(unlocked),
    .busy_o(busy), .int_raw_o(int_raw), .irq_o(irq_o), .rst_req_o(rst_req_o));

  wdg_core #(.DW(DW)) u_core (
    .clk_i(slow_clk_i), .rst_ni(slow_rst_n),
    .ld_req_s_i(at_slow[0]), .cnt_en_s_i(cnt_en_s), .snap_ack_s_i(at_slow[2]),
    .ld_val_i(ld_val), .pre_val_i(pre_val),
    .ld_ack_o(ld_ack), .pre_tgl_o(pre_tgl), .exp_tgl_o(exp_tgl),
    .snap_tgl_o(snap_tgl), .snap_data_o(snap_data), .cnt_o(cnt),
    .load_evt_o(load_evt));
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk_i,
  input logic              slow_clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              unlocked,
  input logic [3:0]        ctrl_q,
  input logic              busy,
  input logic [DW-1:0]     ld_val,
  input logic              int_raw,
  input logic              rst_req_o,
  input logic [DW-1:0]     cnt_q,
  input logic              cnt_en_s,
  input logic              load_evt
);
  AST_LOCKED_CTRL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && !(bus_sel_i && bus_wr_i && bus_addr_i == A_LOCK)) |=> $stable(ctrl_q)); // R2

  AST_BUSY_LOAD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && bus_sel_i && bus_wr_i && bus_addr_i == A_LOAD_LO) |=> $stable(ld_val)); // R5

  AST_CNT_FROZEN: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (!cnt_en_s && !load_evt) |=> $stable(cnt_q)); // R6

  AST_ZERO_HOLD: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_evt) |=> (cnt_q == '0)); // R6

  AST_INT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_raw && !(bus_sel_i && bus_wr_i)) |=> int_raw); // R8

  AST_RSTREQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !(bus_sel_i && bus_wr_i)) |=> rst_req_o); // R10
endmodule

bind wdg_top wdg_checker #(.DW(DW)) u_chk (
  .clk_i(clk_i), .slow_clk_i(slow_clk_i), .rst_ni(rst_ni),
  .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .unlocked(unlocked), .ctrl_q(ctrl), .busy(busy), .ld_val(ld_val),
  .int_raw(int_raw), .rst_req_o(rst_req_o), .cnt_q(cnt),
  .cnt_en_s(cnt_en_s), .load_evt(load_evt));

// File: tb/wdg_top_bench.sv
`timescale 1ns/100ps
module wdg_top_bench;
  localparam logic [5:0] O_LLO = 6'h00, O_LHI = 6'h04, O_CTL = 6'h08, O_CLR = 6'h0C;
  localparam logic [5:0] O_RAW = 6'h10, O_MSK = 6'h14, O_CLO = 6'h18, O_CHI = 6'h1C;
  localparam logic [5:0] O_LCK = 6'h20, O_PLO = 6'h2C, O_PHI = 6'h30;

  logic        clk = 1'b0, slow_clk = 1'b0, rst_n;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rst_req;
  int          total = 0, bad = 0, slow_n = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;
  always #18.5 slow_clk = ~slow_clk;
  always @(posedge slow_clk) slow_n++;

  wdg_top u_wdg_top (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req));

  function automatic int pre_gap(int n, int p); return n - p; endfunction
  function automatic int exp_gap(int n); return n; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0; rd = 1'b0;
  endtask

  task automatic rd_cnt(output logic [31:0] c);
    logic [31:0] h, l;
    brd(O_CHI, h);
    brd(O_CLO, l);
    c = {h[15:0], l[15:0]};
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    int polls = 0;
    brd(O_RAW, r);
    while (r[4] && polls < 200) begin
      brd(O_RAW, r);
      polls++;
    end
    chk("R5 busy eventually clears", {31'b0, r[4]}, 32'd0);
  endtask

  task automatic do_load(input logic [31:0] n, input logic [31:0] p);
    logic [31:0] r;
    int polls = 0;
    bwr(O_PHI, {16'h0, p[31:16]});
    bwr(O_PLO, {16'h0, p[15:0]});
    bwr(O_LHI, {16'h0, n[31:16]});
    bwr(O_LLO, {16'h0, n[15:0]});
    brd(O_RAW, r);
    chk("R5 busy right after commit", {31'b0, r[4]}, 32'd1);
    while (r[4] && polls < 200) begin
      brd(O_RAW, r);
      polls++;
    end
    // each poll spans two bus cycles; window is 2..3 slow periods plus sync
    chk_rng("R5 busy window in bus cycles", 2 * polls + 2, 16, 38);
    repeat (8) @(posedge slow_clk);
  endtask

  task automatic wait_bit(input int b, input int limit, output int el);
    logic [31:0] r;
    int start = slow_n;
    brd(O_RAW, r);
    while (!r[b] && (slow_n - start) < limit) brd(O_RAW, r);
    el = slow_n - start;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, c1, c2;
    int el, n, p, start;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(posedge slow_clk);

    // R1 reset state
    brd(O_CTL, r); chk("R1 ctrl after reset", r, 32'd0);
    brd(O_RAW, r); chk("R1 raw after reset", r, 32'd0);
    brd(O_LCK, r); chk("R1 locked after reset", r, 32'd0);
    rd_cnt(r);     chk("R1 count after reset", r, 32'd0);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
    chk("R1 rst_req low", {31'b0, rst_req}, 32'd0);

    // R2 writes while locked are dropped
    bwr(O_CTL, 32'hF);
    brd(O_CTL, r); chk("R2 locked ctrl write dropped", r, 32'd0);
    bwr(O_LCK, 32'h1234);
    brd(O_LCK, r); chk("R2 wrong key stays locked", r, 32'd0);
    bwr(O_LCK, 32'h0000E551);
    brd(O_LCK, r); chk("R2 key unlocks", r, 32'd1);

    // R3 control readback
    bwr(O_CTL, 32'h4);
    brd(O_CTL, r); chk("R3 mode flag readback", r, 32'h4);
    bwr(O_CTL, 32'h0);

    // R5 load while busy is dropped
    bwr(O_PHI, 32'h0); bwr(O_PLO, 32'd10); bwr(O_LHI, 32'h0);
    bwr(O_LLO, 32'h50);
    bwr(O_LLO, 32'h99);
    wait_idle();
    repeat (8) @(posedge slow_clk);
    rd_cnt(r); chk("R5 second load during busy ignored", r, 32'h50);

    // R4 R7 both halves
    do_load(32'h0001_2345, 32'd10);
    rd_cnt(r); chk("R4 R7 full 32-bit reload readback", r, 32'h0001_2345);

    // R8 R9 pre-timeout, masked first
    do_load(32'h50, 32'd10);
    bwr(O_MSK, 32'h1);
    bwr(O_CTL, 32'h3);
    wait_bit(0, 200, el);
    chk_rng("R8 slow cycles to early warning", el, pre_gap(32'h50, 10), pre_gap(32'h50, 10) + 5);
    chk("R9 masked irq stays low", {31'b0, irq}, 32'd0);
    bwr(O_MSK, 32'h0);
    chk("R9 unmasked irq high", {31'b0, irq}, 32'd1);

    // R6 freeze
    bwr(O_CTL, 32'h1);
    repeat (6) @(posedge slow_clk);
    rd_cnt(c1);
    chk_rng("R6 frozen count near threshold", int'(c1), 1, 10);
    repeat (20) @(posedge slow_clk);
    rd_cnt(c2);
    chk("R6 count holds while disabled", c2, c1);

    // R11 clear while locked
    bwr(O_LCK, 32'h0);
    bwr(O_CLR, 32'h9);
    brd(O_RAW, r); chk("R11 locked clear ignored", {31'b0, r[0]}, 32'd1);
    bwr(O_CTL, 32'h0);
    brd(O_CTL, r); chk("R2 relocked ctrl write dropped", r, 32'h1);
    bwr(O_LCK, 32'h0000E551);
    bwr(O_CLR, 32'h1);
    brd(O_RAW, r); chk("R8 clear drops raw bit 0", {31'b0, r[0]}, 32'd0);
    chk("R9 irq low after clear", {31'b0, irq}, 32'd0);

    // R10 expiry with reset enabled, R6 resume and hold at zero
    bwr(O_CTL, 32'hB);
    wait_bit(3, 60, el);
    chk_rng("R6 resume reaches expiry", el, 1, 20);
    chk("R10 reset request raised", {31'b0, rst_req}, 32'd1);
    repeat (10) @(posedge slow_clk);
    rd_cnt(r); chk("R6 count at zero", r, 32'd0);
    repeat (20) @(posedge slow_clk);
    rd_cnt(r); chk("R6 count stays at zero", r, 32'd0);
    bwr(O_CLR, 32'h8);
    brd(O_RAW, r); chk("R10 clear drops raw bit 3", {31'b0, r[3]}, 32'd0);
    chk("R10 reset request dropped", {31'b0, rst_req}, 32'd0);

    // random reload / threshold pairs, reset request disabled
    for (int it = 0; it < 6; it++) begin
      n = 20 + int'($urandom % 60);
      p = 2 + int'($urandom % (n - 4));
      bwr(O_CTL, 32'h0);
      bwr(O_CLR, 32'h9);
      do_load(n, p);
      rd_cnt(r); chk("R4 random reload readback", r, n);
      bwr(O_CTL, 32'h3);
      start = slow_n;
      wait_bit(0, n + 20, el);
      chk_rng("R8 random early-warning gap", slow_n - start, pre_gap(n, p), pre_gap(n, p) + 6);
      chk("R9 random irq high", {31'b0, irq}, 32'd1);
      wait_bit(3, n + 20, el);
      chk_rng("R10 random expiry gap", slow_n - start, exp_gap(n), exp_gap(n) + 6);
      chk("R10 no request without enable", {31'b0, rst_req}, 32'd0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule